// File: doc/BRIEF.md
# Charge-Transfer Sense Switch Sequencer

This block controls the switches of one capacitive charge-transfer sense channel and the output stage behind it. It performs one pixel conversion per start request. First it charges the sensing electrode and a dummy cancel capacitor together. It then sets the amplifier reference, releases the electrode, and moves the charge onto the sense amplifier and its hold capacitor. Last, it presets the output stage and moves the held charge to the output. Each switch has one control bit, and a bit at 1 means the switch is closed. Every switch is open whenever no conversion is running.

The lengths of the nine phases and a mask of optional guard clocks are sampled when a start is accepted, so each conversion runs with the settings it started with. A guard clock opens every switch for one cycle between two neighbouring phases. After the last phase the block raises a one-clock completion pulse and returns to idle. States: IDLE, RUN (phases 1 to 9, tracked by a phase index), GAP (guard clock) and DONE. Transitions: IDLE->RUN on start; RUN->RUN when a phase ends and no guard is enabled; RUN->GAP when a phase ends and its guard bit is set; GAP->RUN after one clock; RUN->DONE when phase 9 ends; DONE->IDLE after one clock.

Top module: `cts_switch_seq`

## Requirements
- R1: During reset and in idle, `sw_ctl` is 0 (all switches open) and `done` is low.
- R2: A start sampled high in idle begins phase 1 on the next clock. Bit positions of `sw_ctl`: 0 precharge, 1 reset, 2 cell select, 3 dummy charge, 4 reference set, 5 transfer, 6 hold sample, 7 output preset, 8 output transfer, 9 output hold. Phase 1 drives 10'h00F.
- R3: Phase 2 keeps only cell select closed (10'h004). Phase 3 adds reference set (10'h014). Phase 4 opens cell select only (10'h010).
- R4: Phase 5 closes reset, transfer and hold sample on top of reference set (10'h072). Phase 6 opens hold sample (10'h032).
- R5: Phase 7 closes output preset (10'h0B2), and phase 8 opens it again (10'h032).
- R6: Phase 9 closes output transfer and output hold (10'h332).
- R7: Phase k lasts `phase_len[(k-1)*LEN_W +: LEN_W]` clocks. A programmed length of 0 lasts 1 clock.
- R8: When `gap_en[k-1]` is set, one clock with `sw_ctl` = 0 is inserted between phase k and phase k+1.
- R9: After phase 9, `done` is high for exactly one clock with `sw_ctl` = 0, and the block is then idle.
- R10: A start request while a conversion is in progress has no effect.
- R11: Changes to `phase_len` or `gap_en` after a start is accepted do not affect that conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request, sampled only in idle |
| phase_len | input | 9*LEN_W | Per-phase length in clocks; phase k occupies slice k-1 |
| gap_en | input | 8 | Guard clock enable; bit k-1 places a guard after phase k |
| sw_ctl | output | 10 | Switch controls, 1 = closed |
| done | output | 1 | One-clock completion pulse |

## Verification
The hardest case to reach is a new start request, together with new settings, arriving while a conversion is still running. The stimulus pulses start a few clocks into a run and at the same moment drives every length to its maximum and inverts the guard mask. The expected per-cycle switch stream is built from the settings captured at the original start, so the disturbance must leave no trace. Zero lengths, a mixed guard mask, a full guard mask and maximum lengths are each run as separate conversions.

// File: rtl/cts_seq_pkg.sv
package cts_seq_pkg;
    localparam int NUM_PH  = 9;
    localparam int NUM_SW  = 10;
    localparam int NUM_GAP = NUM_PH - 1;
    localparam int PH_W    = $clog2(NUM_PH + 1);

    localparam int SW_PRE  = 0;
    localparam int SW_RST  = 1;
    localparam int SW_SEL  = 2;
    localparam int SW_DMY  = 3;
    localparam int SW_REF  = 4;
    localparam int SW_XFR  = 5;
    localparam int SW_HSM  = 6;
    localparam int SW_OPRE = 7;
    localparam int SW_OXFR = 8;
    localparam int SW_OHLD = 9;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_GAP,
        ST_DONE
    } seq_state_t;
endpackage

// File: rtl/cts_switch_decode.sv
module cts_switch_decode
    import cts_seq_pkg::*;
(
    input  logic [PH_W-1:0]   ph_idx,
    output logic [NUM_SW-1:0] sw
);
    always_comb begin
        sw = '0;
        unique case (ph_idx)
            PH_W'(1): begin
                sw[SW_PRE] = 1'b1;
                sw[SW_RST] = 1'b1;
                sw[SW_SEL] = 1'b1;
                sw[SW_DMY] = 1'b1;
            end
            PH_W'(2): sw[SW_SEL] = 1'b1;
            PH_W'(3): begin
                sw[SW_SEL] = 1'b1;
                sw[SW_REF] = 1'b1;
            end
            PH_W'(4): sw[SW_REF] = 1'b1;
            PH_W'(5): begin
                sw[SW_REF] = 1'b1;
                sw[SW_RST] = 1'b1;
                sw[SW_XFR] = 1'b1;
                sw[SW_HSM] = 1'b1;
            end
            PH_W'(6), PH_W'(8): begin
                sw[SW_REF] = 1'b1;
                sw[SW_RST] = 1'b1;
                sw[SW_XFR] = 1'b1;
            end
            PH_W'(7): begin
                sw[SW_REF]  = 1'b1;
                sw[SW_RST]  = 1'b1;
                sw[SW_XFR]  = 1'b1;
                sw[SW_OPRE] = 1'b1;
            end
            PH_W'(9): begin
                sw[SW_REF]  = 1'b1;
                sw[SW_RST]  = 1'b1;
                sw[SW_XFR]  = 1'b1;
                sw[SW_OXFR] = 1'b1;
                sw[SW_OHLD] = 1'b1;
            end
            default: sw = '0;
        endcase
    end
endmodule

// File: rtl/cts_phase_timer.sv
module cts_phase_timer #(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    output logic             expire
);
    logic [LEN_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= (load_len == '0) ? '0 : load_len - LEN_W'(1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - LEN_W'(1);
        end
    end

    assign expire = (cnt_q == '0);

    // R7: a phase longer than one clock never ends on its first clock
    assert_len_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_len > LEN_W'(1)) |=> !expire);
endmodule

// File: rtl/cts_seq_fsm.sv
module cts_seq_fsm
    import cts_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               expire,
    input  logic [NUM_GAP-1:0] gap_q,
    output seq_state_t         state,
    output logic [PH_W-1:0]    ph_idx,
    output logic               load,
    output logic [PH_W-1:0]    load_ph
);
    seq_state_t      state_n;
    logic [PH_W-1:0] ph_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            ph_idx <= '0;
        end else begin
            state  <= state_n;
            ph_idx <= ph_n;
        end
    end

    always_comb begin
        state_n = state;
        ph_n    = ph_idx;
        load    = 1'b0;
        load_ph = PH_W'(1);
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_n = ST_RUN;
                    ph_n    = PH_W'(1);
                    load    = 1'b1;
                end
            end
            ST_RUN: begin
                if (expire) begin
                    if (ph_idx == PH_W'(NUM_PH)) begin
                        state_n = ST_DONE;
                        ph_n    = '0;
                    end else if (gap_q[3'(ph_idx - PH_W'(1))]) begin
                        state_n = ST_GAP;
                    end else begin
                        ph_n    = ph_idx + PH_W'(1);
                        load    = 1'b1;
                        load_ph = ph_idx + PH_W'(1);
                    end
                end
            end
            ST_GAP: begin
                state_n = ST_RUN;
                ph_n    = ph_idx + PH_W'(1);
                load    = 1'b1;
                load_ph = ph_idx + PH_W'(1);
            end
            ST_DONE: begin
                state_n = ST_IDLE;
                ph_n    = '0;
            end
            default: begin
                state_n = ST_IDLE;
                ph_n    = '0;
            end
        endcase
    end

    // R8: a guard lasts exactly one clock and resumes with the next phase
    assert_gap_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP) |=> (state == ST_RUN && ph_idx == $past(ph_idx) + PH_W'(1)));
    // R7: the phase index stays within 1..9 while running
    assert_phase_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> (ph_idx >= PH_W'(1) && ph_idx <= PH_W'(NUM_PH)));
    // R10: a start request while running leaves the phase unchanged unless the timer ends it
    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && start && !expire) |=> (state == ST_RUN && $stable(ph_idx)));
endmodule

// File: rtl/cts_switch_seq.sv
module cts_switch_seq
    import cts_seq_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [NUM_PH*LEN_W-1:0] phase_len,
    input  logic [NUM_GAP-1:0]      gap_en,
    output logic [NUM_SW-1:0]       sw_ctl,
    output logic                    done
);
    seq_state_t         state;
    logic [PH_W-1:0]    ph_idx;
    logic               load;
    logic [PH_W-1:0]    load_ph;
    logic               expire;
    logic [LEN_W-1:0]   load_len;
    logic [NUM_SW-1:0]  dec_sw;
    logic [NUM_GAP-1:0] gap_q;
    logic [LEN_W-1:0]   cfg_len [NUM_PH];
    logic               accept;

    assign accept = (state == ST_IDLE) && start;

    generate
        for (genvar g = 0; g < NUM_PH; g++) begin : g_cfg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      cfg_len[g] <= '0;
                else if (accept) cfg_len[g] <= phase_len[g*LEN_W +: LEN_W];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      gap_q <= '0;
        else if (accept) gap_q <= gap_en;
    end

    always_comb begin
        if (state == ST_IDLE) load_len = phase_len[0 +: LEN_W];
        else                  load_len = cfg_len[4'(load_ph - PH_W'(1))];
    end

    cts_seq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .expire  (expire),
        .gap_q   (gap_q),
        .state   (state),
        .ph_idx  (ph_idx),
        .load    (load),
        .load_ph (load_ph)
    );

    cts_phase_timer #(.LEN_W(LEN_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_len (load_len),
        .expire   (expire)
    );

    cts_switch_decode u_dec (
        .ph_idx (ph_idx),
        .sw     (dec_sw)
    );

    always_comb begin
        sw_ctl = (state == ST_RUN) ? dec_sw : '0;
        done   = (state == ST_DONE);
    end

    // R2: an accepted start opens the sequence with the precharge set
    assert_start_phase1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> (sw_ctl == 10'h00F));
    // R9: completion is a single clock with every switch open
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sw_ctl == '0));
    // R6: completion always follows the output-transfer phase
    assert_done_after_p9_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(sw_ctl) == 10'h332));
    // R11: captured settings hold for the whole conversion
    assert_cfg_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(gap_q));
endmodule

// File: tb/tb_cts_switch_seq.sv
module tb_cts_switch_seq;
    localparam int CLK_P   = 10;
    localparam int LEN_W   = 8;
    localparam int NPH     = 9;
    localparam int WDOG    = 100000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [NPH*LEN_W-1:0] phase_len = '0;
    logic [7:0]        gap_en = '0;
    logic [9:0]        sw_ctl;
    logic              done;

    int n_chk = 0;
    int n_fail = 0;
    logic [10:0] exp_q [$];
    string       tag_q [$];
    bit          mon_on = 1'b0;

    cts_switch_seq #(.LEN_W(LEN_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .phase_len(phase_len),
        .gap_en(gap_en), .sw_ctl(sw_ctl), .done(done)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [9:0] pat(input int p);
        case (p)
            1: return 10'h00F;
            2: return 10'h004;
            3: return 10'h014;
            4: return 10'h010;
            5: return 10'h072;
            6: return 10'h032;
            7: return 10'h0B2;
            8: return 10'h032;
            9: return 10'h332;
            default: return 10'h000;
        endcase
    endfunction

    function automatic string ptag(input int p);
        case (p)
            1: return "R2 R7";
            2, 3, 4: return "R3 R7";
            5, 6: return "R4 R7";
            7, 8: return "R5 R7";
            default: return "R6 R7";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [10:0] act, input logic [10:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // driver: pushes expected per-clock output stream, then starts the conversion
    task automatic run_seq(input logic [NPH*LEN_W-1:0] lens, input logic [7:0] gaps, input bit disturb);
        string extra;
        extra = disturb ? " R10 R11" : "";
        @(negedge clk);
        phase_len = lens;
        gap_en    = gaps;
        start     = 1'b1;
        for (int p = 1; p <= NPH; p++) begin
            int eff;
            eff = int'(lens[(p-1)*LEN_W +: LEN_W]);
            if (eff == 0) eff = 1;
            for (int c = 0; c < eff; c++) begin
                exp_q.push_back({1'b0, pat(p)});
                tag_q.push_back({ptag(p), extra});
            end
            if (p < NPH && gaps[p-1]) begin
                exp_q.push_back(11'h000);
                tag_q.push_back({"R8", extra});
            end
        end
        exp_q.push_back(11'h400);
        tag_q.push_back({"R9", extra});
        exp_q.push_back(11'h000);
        tag_q.push_back({"R9", extra});
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            repeat (3) @(negedge clk);
            start     = 1'b1;
            phase_len = '1;
            gap_en    = ~gaps;
            @(negedge clk);
            start = 1'b0;
        end
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // monitor: compares each clock's outputs with the scoreboard
    initial begin
        wait (mon_on);
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            if (exp_q.size() > 0) begin
                logic [10:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({done, sw_ctl} === e, t, {done, sw_ctl}, e);
            end else begin
                check({done, sw_ctl} === 11'h000, "R1 idle", {done, sw_ctl}, 11'h000);
            end
        end
    end

    initial begin
        int cyc = 0;
        while (cyc < WDOG) begin
            @(posedge clk);
            cyc++;
        end
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        check({done, sw_ctl} === 11'h000, "R1 reset", {done, sw_ctl}, 11'h000);
        rst_n = 1'b1;
        @(negedge clk);
        check({done, sw_ctl} === 11'h000, "R1 after reset", {done, sw_ctl}, 11'h000);
        mon_on = 1'b1;
        // all phases one clock, no guards
        run_seq({9{8'd1}}, 8'h00, 1'b0);
        // mixed lengths including zero, mixed guards
        run_seq({8'd5, 8'd1, 8'd2, 8'd1, 8'd4, 8'd1, 8'd2, 8'd0, 8'd3}, 8'b1010_0101, 1'b0);
        // every guard enabled, start and new settings mid-run
        run_seq({9{8'd2}}, 8'hFF, 1'b1);
        // maximum lengths
        run_seq({9{8'd255}}, 8'h10, 1'b0);
        summary();
    end
endmodule